// File: doc/BRIEF.md
# Focus Acquisition Sequencer

This block brings an optical pickup's focus actuator from an unknown position into closed-loop control. After a start command it sweeps the actuator with a programmable triangular search waveform. On every sample it watches two inputs: the summed central-aperture light level and the normalized focus error. A focus-OK flag is set once the light level rises to a start threshold. While that flag holds, a focus error that grows past its own threshold arms the handover. The next sign change of the focus error then switches the external PID filter into the loop. The sweep stops at the value it had reached.

The sequencer also watches for focus loss while the loop is closed. A run of consecutive samples without focus-OK means focus is lost. The block then reports that state briefly and starts a fresh sweep from the programmed centre, with no command needed. All decisions are taken on sample strobes. Removing the start command returns the block to its quiet state on the next clock.

Top module: `focus_acq_seq`

## Requirements
- R1: While reset is held and directly after it, the state code is 0 (idle), the drive output is 0, and focus-OK and PID-enable are both low.
- R2: In idle with start high, the next clock moves to the search state (code 1) with the drive equal to the programmed offset. Start low in any state returns to idle on the next clock, with drive 0, focus-OK low and PID-enable low.
- R3: In the search and armed states, each strobe moves the drive by the step value in the current direction. The first move after a (re)start goes upward. A move that would reach or pass offset+height stops exactly there and turns downward. A move that would reach or pass offset−height stops exactly there and turns upward. Between strobes the drive does not change.
- R4: At each strobe outside idle, focus-OK goes low if the CA level is below the drop level. Otherwise it goes high if the CA level is at or above the start level. Otherwise it keeps its value. Between strobes it does not change.
- R5: In the search state, a strobe moves to armed (code 2) when focus-OK was already high before that strobe and the magnitude of the focus error is at or above the focus-error start level.
- R6: In the armed state, a strobe with focus-OK low returns to search. Otherwise, a strobe whose focus-error sign bit differs from the sign bit of the previous strobe's sample moves to closed (code 3). In closed, PID-enable is high and the drive holds its last value.
- R7: In closed, a count of LOSS_SAMPLES consecutive strobes with focus-OK low moves to lost (code 4) and drops PID-enable. A strobe with focus-OK high restarts that count.
- R8: In lost, the next strobe moves to search with the drive reloaded to the offset and the direction set upward.
- R9: The state output uses exactly the codes 0 to 4 listed above and never shows any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run command; low forces idle |
| sample_i | input | 1 | Strobe marking a valid CA/FE sample |
| ca_i | input | CA_W | Central-aperture sum level, unsigned |
| fe_i | input | FE_W | Normalized focus error, two's complement |
| ca_start_i | input | CA_W | CA level that sets focus-OK |
| ca_drop_i | input | CA_W | CA level below which focus-OK clears |
| fe_start_i | input | FE_W-1 | Focus-error magnitude that arms the handover |
| ramp_offset_i | input | DRV_W | Centre of the search triangle, signed |
| ramp_height_i | input | DRV_W-1 | Half peak-to-peak swing of the triangle |
| ramp_step_i | input | DRV_W-1 | Drive change per strobe |
| drive_o | output | DRV_W | Actuator search drive, signed, clamped to its range |
| pid_en_o | output | 1 | Closed-loop PID enable |
| fok_o | output | 1 | Focus-OK flag |
| state_o | output | 3 | Sequencer state code |

## Verification
The assertions check on every cycle that the state code is legal and that idle is quiet. They also check the order of entries into armed, closed and lost, which needs focus-OK and a strobe on the cycle before, and that the drive and focus-OK change only on strobes or when the block is cleared. Only the bench's scenarios can show the exact numbers. These include the drive values at each bounce of the triangle, the focus-error threshold comparison, and the zero-crossing decision. They also include the exact strobe on which the loss count expires, with a focus-OK blip resetting the count partway, and the reload to the offset on restart.

// File: rtl/focus_acq_pkg.sv
package focus_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RAMP   = 3'd1,
        ST_ARMED  = 3'd2,
        ST_CLOSED = 3'd3,
        ST_LOST   = 3'd4
    } acq_state_e;

endpackage

// File: rtl/focus_ramp_gen.sv
module focus_ramp_gen #(
    parameter int DRV_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    restart_i,
    input  logic                    advance_i,
    input  logic signed [DRV_W-1:0] offset_i,
    input  logic        [DRV_W-2:0] height_i,
    input  logic        [DRV_W-2:0] step_i,
    output logic signed [DRV_W-1:0] pos_o
);

    // Extended arithmetic width: offset + height + step cannot overflow.
    localparam int AW = DRV_W + 2;
    localparam logic signed [AW-1:0] OUT_MAX = AW'((64'sd1 <<< (DRV_W - 1)) - 1);
    localparam logic signed [AW-1:0] OUT_MIN = -AW'(64'sd1 <<< (DRV_W - 1));

    typedef struct packed {
        logic signed [AW-1:0] pos;
        logic                 up;
    } ramp_t;

    ramp_t ramp_d, ramp_q;

    logic signed [AW-1:0] off_x, hgt_x, stp_x, top_x, bot_x, trial_x;

    always_comb begin
        off_x   = {{2{offset_i[DRV_W-1]}}, offset_i};
        hgt_x   = {3'b000, height_i};
        stp_x   = {3'b000, step_i};
        top_x   = off_x + hgt_x;
        bot_x   = off_x - hgt_x;
        trial_x = ramp_q.up ? (ramp_q.pos + stp_x) : (ramp_q.pos - stp_x);

        ramp_d = ramp_q;
        if (restart_i) begin
            ramp_d.pos = off_x;
            ramp_d.up  = 1'b1;
        end else if (advance_i) begin
            if (ramp_q.up) begin
                if (trial_x >= top_x) begin
                    ramp_d.pos = top_x;
                    ramp_d.up  = 1'b0;
                end else begin
                    ramp_d.pos = trial_x;
                end
            end else begin
                if (trial_x <= bot_x) begin
                    ramp_d.pos = bot_x;
                    ramp_d.up  = 1'b1;
                end else begin
                    ramp_d.pos = trial_x;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q <= '{pos: '0, up: 1'b1};
        end else begin
            ramp_q <= ramp_d;
        end
    end

    // Guard the output range when the programmed triangle exceeds it.
    always_comb begin
        if (ramp_q.pos > OUT_MAX) begin
            pos_o = OUT_MAX[DRV_W-1:0];
        end else if (ramp_q.pos < OUT_MIN) begin
            pos_o = OUT_MIN[DRV_W-1:0];
        end else begin
            pos_o = ramp_q.pos[DRV_W-1:0];
        end
    end

endmodule

// File: rtl/focus_ok_det.sv
module focus_ok_det #(
    parameter int CA_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            sample_i,
    input  logic [CA_W-1:0] ca_i,
    input  logic [CA_W-1:0] ca_start_i,
    input  logic [CA_W-1:0] ca_drop_i,
    input  logic            fe_neg_i,
    output logic            fok_o,
    output logic            sign_o
);

    typedef struct packed {
        logic fok;
        logic sign;
    } okdet_t;

    okdet_t ok_d, ok_q;

    always_comb begin
        ok_d = ok_q;
        if (sample_i) begin
            ok_d.sign = fe_neg_i;
        end
        if (clear_i) begin
            ok_d.fok = 1'b0;
        end else if (sample_i) begin
            if (ca_i < ca_drop_i) begin
                ok_d.fok = 1'b0;
            end else if (ca_i >= ca_start_i) begin
                ok_d.fok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= '{fok: 1'b0, sign: 1'b0};
        end else begin
            ok_q <= ok_d;
        end
    end

    assign fok_o  = ok_q.fok;
    assign sign_o = ok_q.sign;

endmodule

// File: rtl/focus_loss_timer.sv
module focus_loss_timer #(
    parameter int LOSS_SAMPLES = 132
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic sample_i,
    input  logic fok_i,
    output logic expire_o
);

    localparam int CW = $clog2(LOSS_SAMPLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOSS_SAMPLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } loss_t;

    loss_t lt_d, lt_q;
    logic  bump;

    always_comb begin
        bump     = active_i && sample_i && !fok_i;
        expire_o = bump && (lt_q.cnt == LAST);
        lt_d     = lt_q;
        if (!active_i || (sample_i && fok_i)) begin
            lt_d.cnt = '0;
        end else if (bump) begin
            lt_d.cnt = lt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lt_q <= '{cnt: '0};
        end else begin
            lt_q <= lt_d;
        end
    end

endmodule

// File: rtl/focus_acq_seq.sv
module focus_acq_seq
    import focus_acq_pkg::*;
#(
    parameter int CA_W         = 12,
    parameter int FE_W         = 12,
    parameter int DRV_W        = 12,
    parameter int LOSS_SAMPLES = 132
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    sample_i,
    input  logic        [CA_W-1:0]  ca_i,
    input  logic signed [FE_W-1:0]  fe_i,
    input  logic        [CA_W-1:0]  ca_start_i,
    input  logic        [CA_W-1:0]  ca_drop_i,
    input  logic        [FE_W-2:0]  fe_start_i,
    input  logic signed [DRV_W-1:0] ramp_offset_i,
    input  logic        [DRV_W-2:0] ramp_height_i,
    input  logic        [DRV_W-2:0] ramp_step_i,
    output logic signed [DRV_W-1:0] drive_o,
    output logic                    pid_en_o,
    output logic                    fok_o,
    output logic        [2:0]       state_o
);

    typedef struct packed {
        acq_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    logic            fe_neg, fe_over, zero_cross;
    logic [FE_W-1:0] fe_mag;
    logic            fok, prev_sign, loss_expire;
    logic            ramp_restart, ramp_advance, clear_ok, closed;
    logic signed [DRV_W-1:0] ramp_pos;

    always_comb begin
        fe_neg     = fe_i[FE_W-1];
        fe_mag     = fe_neg ? (~fe_i + 1'b1) : fe_i;
        fe_over    = fe_mag >= {1'b0, fe_start_i};
        zero_cross = fe_neg != prev_sign;
    end

    always_comb begin
        seq_d = seq_q;
        if (!start_i) begin
            seq_d.st = ST_IDLE;
        end else begin
            unique case (seq_q.st)
                ST_IDLE:   seq_d.st = ST_RAMP;
                ST_RAMP:   if (sample_i && fok && fe_over) seq_d.st = ST_ARMED;
                ST_ARMED: begin
                    if (sample_i) begin
                        if (!fok) begin
                            seq_d.st = ST_RAMP;
                        end else if (zero_cross) begin
                            seq_d.st = ST_CLOSED;
                        end
                    end
                end
                ST_CLOSED: if (loss_expire) seq_d.st = ST_LOST;
                ST_LOST:   if (sample_i) seq_d.st = ST_RAMP;
                default:   seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        closed       = seq_q.st == ST_CLOSED;
        clear_ok     = !start_i || (seq_q.st == ST_IDLE);
        ramp_restart = (seq_q.st == ST_IDLE) || ((seq_q.st == ST_LOST) && sample_i);
        ramp_advance = start_i && sample_i &&
                       ((seq_q.st == ST_RAMP) || (seq_q.st == ST_ARMED));
    end

    focus_ramp_gen #(.DRV_W(DRV_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ramp_restart),
        .advance_i (ramp_advance),
        .offset_i  (ramp_offset_i),
        .height_i  (ramp_height_i),
        .step_i    (ramp_step_i),
        .pos_o     (ramp_pos)
    );

    focus_ok_det #(.CA_W(CA_W)) u_okdet (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_ok),
        .sample_i   (sample_i),
        .ca_i       (ca_i),
        .ca_start_i (ca_start_i),
        .ca_drop_i  (ca_drop_i),
        .fe_neg_i   (fe_neg),
        .fok_o      (fok),
        .sign_o     (prev_sign)
    );

    focus_loss_timer #(.LOSS_SAMPLES(LOSS_SAMPLES)) u_loss (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (closed),
        .sample_i (sample_i),
        .fok_i    (fok),
        .expire_o (loss_expire)
    );

    assign drive_o  = (seq_q.st == ST_IDLE) ? '0 : ramp_pos;
    assign pid_en_o = closed;
    assign fok_o    = fok;
    assign state_o  = seq_q.st;

endmodule

// File: rtl/focus_acq_chk.sv
module focus_acq_chk #(
    parameter int DRV_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic                    sample_i,
    input logic signed [DRV_W-1:0] drive_o,
    input logic                    pid_en_o,
    input logic                    fok_o,
    input logic        [2:0]       state_o
);

    a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> (!fok_o && !pid_en_o && drive_o == '0));

    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (state_o == 3'd0));

    a_r3_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd0 && $past(state_o) != 3'd0 && !$past(sample_i)) |-> $stable(drive_o));

    a_r4_fok_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fok_o != $past(fok_o)) |-> ($past(sample_i) || !$past(start_i) || $past(state_o) == 3'd0));

    a_r5_arm_needs_fok: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && $past(state_o) == 3'd1) |-> ($past(fok_o) && $past(sample_i)));

    a_r6_close_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pid_en_o) |-> ($past(state_o) == 3'd2 && $past(fok_o) && $past(sample_i)));

    a_r7_lost_from_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3 && !$past(fok_o)));

endmodule

bind focus_acq_seq focus_acq_chk #(.DRV_W(DRV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sample_i (sample_i),
    .drive_o  (drive_o),
    .pid_en_o (pid_en_o),
    .fok_o    (fok_o),
    .state_o  (state_o)
);

// File: tb/focus_acq_seq_test.sv
module focus_acq_seq_test;

    localparam int LS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic               start = 1'b0, smp = 1'b0;
    logic        [11:0] ca = '0, ca_st = '0, ca_dr = '0;
    logic signed [11:0] fe = '0, off = '0;
    logic        [10:0] fe_st = '0, hgt = '0, stp = '0;
    logic signed [11:0] drive;
    logic               pid, fok;
    logic        [2:0]  state;

    int checks = 0;
    int fails  = 0;

    focus_acq_seq #(.LOSS_SAMPLES(LS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sample_i(smp),
        .ca_i(ca), .fe_i(fe), .ca_start_i(ca_st), .ca_drop_i(ca_dr),
        .fe_start_i(fe_st), .ramp_offset_i(off), .ramp_height_i(hgt),
        .ramp_step_i(stp), .drive_o(drive), .pid_en_o(pid), .fok_o(fok),
        .state_o(state)
    );

    // Reference model state, derived from the requirements
    int   m_state = 0;
    logic m_fok = 1'b0, m_sign = 1'b0, m_up = 1'b1;
    int   m_pos = 0, m_cnt = 0;

    function automatic int mag_of(input logic signed [11:0] v);
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

    task automatic model_edge();
        int hi, lo, t, ns;
        logic nf, expire;
        hi = int'(off) + int'(hgt);
        lo = int'(off) - int'(hgt);
        ns = m_state;
        expire = (m_state == 3) && smp && !m_fok && (m_cnt + 1 == LS);
        if (!start) ns = 0;
        else case (m_state)
            0: ns = 1;
            1: if (smp && m_fok && mag_of(fe) >= int'(fe_st)) ns = 2;
            2: if (smp) begin
                   if (!m_fok) ns = 1;
                   else if ((fe < 0) != m_sign) ns = 3;
               end
            3: if (expire) ns = 4;
            4: if (smp) ns = 1;
            default: ns = 0;
        endcase
        if (m_state == 0 || (m_state == 4 && smp)) begin
            m_pos = int'(off); m_up = 1'b1;
        end else if (start && smp && (m_state == 1 || m_state == 2)) begin
            t = m_up ? m_pos + int'(stp) : m_pos - int'(stp);
            if (m_up && t >= hi) begin m_pos = hi; m_up = 1'b0; end
            else if (!m_up && t <= lo) begin m_pos = lo; m_up = 1'b1; end
            else m_pos = t;
        end
        if (m_state != 3 || (smp && m_fok)) m_cnt = 0;
        else if (smp) m_cnt = m_cnt + 1;
        nf = m_fok;
        if (!start || m_state == 0) nf = 1'b0;
        else if (smp) begin
            if (ca < ca_dr) nf = 1'b0;
            else if (ca >= ca_st) nf = 1'b1;
        end
        if (smp) m_sign = (fe < 0);
        m_fok = nf;
        m_state = ns;
    endtask

    task automatic check_all(input string tag);
        int   e_drv;
        logic e_pid;
        e_drv = (m_state == 0) ? 0 : m_pos;
        e_pid = (m_state == 3);
        checks++;
        if (int'(state) != m_state || int'(drive) != e_drv || fok !== m_fok || pid !== e_pid) begin
            fails++;
            $display("FAIL %s: got state=%0d drive=%0d fok=%0b pid=%0b, expected state=%0d drive=%0d fok=%0b pid=%0b",
                     tag, state, drive, fok, pid, m_state, e_drv, m_fok, e_pid);
        end
    endtask

    task automatic expect_code(input int code, input string tag);
        checks++;
        if (int'(state) != code) begin
            fails++;
            $display("FAIL %s: state code got %0d expected %0d", tag, state, code);
        end
    endtask

    task automatic tick(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        off = 12'sd100; hgt = 11'd40; stp = 11'd15;
        ca_st = 12'd2000; ca_dr = 12'd1000; fe_st = 11'd300;
        repeat (3) @(negedge clk);
        check_all("R1");
        expect_code(0, "R1");
        rst_n = 1'b1;
        tick("R1");

        // R2: start, drive at offset
        start = 1'b1;
        tick("R2");
        expect_code(1, "R2");

        // R3: triangle bounces, holds between strobes
        for (int i = 0; i < 30; i++) begin
            smp = i[0];
            tick("R3");
        end
        smp = 1'b0;

        // R2: stop and restart
        start = 1'b0; tick("R2");
        expect_code(0, "R2");
        start = 1'b1; tick("R2");

        // R4: focus-OK thresholds
        smp = 1'b1;
        ca = 12'd1500; tick("R4");
        ca = 12'd2000; tick("R4");
        ca = 12'd1500; tick("R4");
        ca = 12'd999;  tick("R4");
        ca = 12'd2500; tick("R4");
        smp = 1'b0; ca = 12'd0; tick("R4");
        smp = 1'b1; ca = 12'd2500;

        // R5: arming
        fe = 12'sd100;  tick("R5");
        fe = -12'sd299; tick("R5");
        fe = -12'sd300; tick("R5");
        expect_code(2, "R5");

        // R6: zero crossing closes the loop, drive frozen
        fe = -12'sd200; tick("R6");
        fe = 12'sd50;   tick("R6");
        expect_code(3, "R9");
        for (int i = 0; i < 4; i++) tick("R6");

        // R7: loss count with a focus-OK blip resetting it
        ca = 12'd500;
        for (int i = 0; i < 4; i++) tick("R7");
        ca = 12'd2500; tick("R7");
        ca = 12'd500;
        for (int i = 0; i < LS + 1; i++) tick("R7");
        expect_code(4, "R7");

        // R8: restart from offset
        tick("R8");
        expect_code(1, "R8");

        // R6: armed then focus-OK lost returns to search
        ca = 12'd2500; fe = 12'sd400;
        tick("R6"); tick("R6"); tick("R6");
        ca = 12'd500; tick("R6"); tick("R6");
        expect_code(1, "R6");

        // Randomized mix across all states
        for (int i = 0; i < 40000; i++) begin
            smp = ($urandom % 3) == 0;
            ca  = (($urandom % 10) == 0) ? 12'($urandom_range(0, 1500)) : 12'($urandom_range(1800, 4095));
            fe  = 12'($urandom_range(0, 4095));
            if (($urandom % 3000) == 0) begin
                start = ~start;
                if (!start) begin
                    off   = 12'($urandom_range(0, 1000)) - 12'sd500;
                    hgt   = 11'($urandom_range(0, 1000));
                    stp   = 11'($urandom_range(1, 200));
                    fe_st = 11'($urandom_range(0, 1500));
                    ca_st = 12'($urandom_range(1500, 2500));
                    ca_dr = 12'($urandom_range(500, 1600));
                end
            end
            tick("R3/R4/R5/R6/R7/R8 random");
        end
        finish_run();
    end

endmodule